// File: doc/BRIEF.md
# Fuse Array Sequenced Read Controller

This block fetches a contiguous run of bytes from a one-time-programmable fuse macro. A one-cycle command supplies a start address and a byte count. The controller first powers the macro up in two stages with a settle gap between them and then releases isolation. It then reads the bytes one at a time through a strobe and ready handshake, and streams them out in ascending address order. Last, it unwinds the power sequence in the reverse order.

Each byte read has its own timeout window. If the macro never answers, the controller stops reading, still runs the full power-down sequence, and only then reports completion with an error flag. An optional burst-mode enable can be held high around the read phase, inside the window where isolation is released. A request for zero bytes completes at once and leaves the macro untouched.

Top module: `fuse_read_seq`

## Requirements
- R1: After reset `isoEn` is 1 and `pwrStage1`, `pwrStage2`, `burstEn`, `fuseRdStrobe`, `outValid`, `done` and `busyErr` are all 0.
- R2: On a request with a nonzero count, `pwrStage1` rises first. `pwrStage2` rises exactly SETTLE_CYC cycles later. `isoEn` falls one cycle after that. No read strobe is issued before `isoEn` has fallen.
- R3: After the last read, or after an abort, `isoEn` rises first. `pwrStage2` falls one cycle later. `pwrStage1` falls exactly SETTLE_CYC cycles after `pwrStage2`. `done` pulses one cycle after `pwrStage1` falls, and then all power outputs are 0 with `isoEn` at 1.
- R4: Each byte read is a one-cycle `fuseRdStrobe` with `fuseAddr` valid. `fuseReady` is ignored during the strobe cycle, so a stale high level left over from the previous read is not taken. The byte on `fuseData` is taken in the first later cycle in which `fuseReady` is high.
- R5: Strobed addresses run from `startAddr` to `startAddr + byteCount - 1` in ascending order. Each byte appears on `outData` for exactly one `outValid` cycle, in the same order.
- R6: A request with `byteCount` 0 pulses `done` with `busyErr` 0. It issues no strobe and raises no power output.
- R7: `fuseReady` must be seen high in one of the TIMEOUT_CYC cycles that follow the strobe cycle. Otherwise no further strobe is issued, the power-down of R3 runs, and `busyErr` is 1 in the `done` cycle. A successful run has `busyErr` 0.
- R8: When `burstCfg` is 1 at the request, `burstEn` rises one cycle after `isoEn` falls and falls one cycle before `isoEn` rises. When `burstCfg` is 0, `burstEn` stays 0 for the whole run.
- R9: `startReq` is ignored while a request is in progress. It changes neither the strobed addresses nor the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request pulse |
| startAddr | input | ADDR_W | First fuse address to read |
| byteCount | input | CNT_W | Number of bytes to read |
| burstCfg | input | 1 | Hold burst mode during the read phase |
| fuseAddr | output | ADDR_W | Address presented to the fuse macro |
| fuseRdStrobe | output | 1 | One-cycle read request to the macro |
| fuseReady | input | 1 | Macro read-complete level |
| fuseData | input | 8 | Byte returned by the macro |
| pwrStage1 | output | 1 | First power enable |
| pwrStage2 | output | 1 | Second power enable |
| isoEn | output | 1 | Isolation between macro and core, 1 = isolated |
| burstEn | output | 1 | Burst-mode enable to the macro |
| outValid | output | 1 | Byte valid on outData |
| outData | output | 8 | Byte read from the fuse array |
| done | output | 1 | One-cycle completion pulse |
| busyErr | output | 1 | High with done when a read timed out |

## Verification
A sequencer stuck in the wrong state shows up at the power and isolation pins within a cycle or two. Examples are isolation being released before the second power stage, or a strobe appearing while isolated. A wrong settle counter moves the edge of the second power stage by whole cycles, and the bench measures that gap exactly in both directions. A bad address or count register shows in the strobed address list and the byte stream of the same request. A broken timeout appears either as a missing `busyErr` at `done` or as a hang, and the boundary latencies on both sides of the timeout window separate the two.

// File: rtl/fuse_read_seq_pkg.sv
package fuse_read_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_UP1,
    S_SETUP,
    S_ISOREL,
    S_BURSTON,
    S_ISSUE,
    S_HOLD,
    S_WAIT,
    S_BURSTOFF,
    S_ISOON,
    S_PWR2OFF,
    S_SETDN,
    S_FINISH
  } seqState_t;

  typedef struct packed {
    logic loadCmd;
    logic pwr1Set;
    logic pwr1Clr;
    logic pwr2Set;
    logic pwr2Clr;
    logic isoSet;
    logic isoClr;
    logic burstSet;
    logic burstClr;
    logic settleLoad;
    logic timeoutLoad;
    logic timerDec;
    logic rdIssue;
    logic capture;
    logic errSet;
    logic doneSet;
  } seqStrobe_t;

  typedef struct packed {
    logic timerZero;
    logic lastByte;
    logic burstCfgd;
    logic cmdEmpty;
  } seqStatus_t;

endpackage

// File: rtl/fuse_read_seq_ctrl.sv
module fuse_read_seq_ctrl
  import fuse_read_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       fuseReady,
  input  seqStatus_t sts,
  output seqStrobe_t stb
);

  seqState_t st;
  seqState_t nxt;
  seqState_t downEntry;

  always_comb begin
    downEntry = sts.burstCfgd ? S_BURSTOFF : S_ISOON;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    case (st)
      S_IDLE: begin
        if (startReq) begin
          stb.loadCmd = 1'b1;
          nxt = sts.cmdEmpty ? S_FINISH : S_UP1;
        end
      end
      S_UP1: begin
        stb.pwr1Set    = 1'b1;
        stb.settleLoad = 1'b1;
        nxt = S_SETUP;
      end
      S_SETUP: begin
        if (sts.timerZero) begin
          stb.pwr2Set = 1'b1;
          nxt = S_ISOREL;
        end else begin
          stb.timerDec = 1'b1;
        end
      end
      S_ISOREL: begin
        stb.isoClr = 1'b1;
        nxt = sts.burstCfgd ? S_BURSTON : S_ISSUE;
      end
      S_BURSTON: begin
        stb.burstSet = 1'b1;
        nxt = S_ISSUE;
      end
      S_ISSUE: begin
        stb.rdIssue     = 1'b1;
        stb.timeoutLoad = 1'b1;
        nxt = S_HOLD;
      end
      S_HOLD: begin
        nxt = S_WAIT;
      end
      S_WAIT: begin
        if (fuseReady) begin
          stb.capture = 1'b1;
          nxt = sts.lastByte ? downEntry : S_ISSUE;
        end else if (sts.timerZero) begin
          stb.errSet = 1'b1;
          nxt = downEntry;
        end else begin
          stb.timerDec = 1'b1;
        end
      end
      S_BURSTOFF: begin
        stb.burstClr = 1'b1;
        nxt = S_ISOON;
      end
      S_ISOON: begin
        stb.isoSet = 1'b1;
        nxt = S_PWR2OFF;
      end
      S_PWR2OFF: begin
        stb.pwr2Clr    = 1'b1;
        stb.settleLoad = 1'b1;
        nxt = S_SETDN;
      end
      S_SETDN: begin
        if (sts.timerZero) begin
          stb.pwr1Clr = 1'b1;
          nxt = S_FINISH;
        end else begin
          stb.timerDec = 1'b1;
        end
      end
      S_FINISH: begin
        stb.doneSet = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

endmodule

// File: rtl/fuse_read_seq_dp.sv
module fuse_read_seq_dp
  import fuse_read_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int CNT_W       = 8,
  parameter int SETTLE_CYC  = 100000,
  parameter int TIMEOUT_CYC = 100000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              burstCfg,
  input  logic [7:0]        fuseData,
  output seqStatus_t        sts,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              fuseRdStrobe,
  output logic              pwrStage1,
  output logic              pwrStage2,
  output logic              isoEn,
  output logic              burstEn,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              done,
  output logic              busyErr
);

  localparam int MAX_WAIT = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int TMR_W    = $clog2(MAX_WAIT + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remCnt;
  logic [TMR_W-1:0]  timer;
  logic              burstCfgQ;
  logic              errQ;

  always_comb begin
    sts.timerZero = (timer == '0);
    sts.lastByte  = (remCnt == CNT_W'(1));
    sts.burstCfgd = burstCfgQ;
    sts.cmdEmpty  = (byteCount == '0);
  end

  // command registers: address and remaining count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remCnt    <= '0;
      burstCfgQ <= 1'b0;
    end else if (stb.loadCmd) begin
      curAddr   <= startAddr;
      remCnt    <= byteCount;
      burstCfgQ <= burstCfg;
    end else if (stb.capture) begin
      curAddr <= curAddr + ADDR_W'(1);
      remCnt  <= remCnt - CNT_W'(1);
    end
  end

  // shared settle / timeout counter
  always_ff @(posedge clk) begin
    if (!rstN)                timer <= '0;
    else if (stb.settleLoad)  timer <= TMR_W'(SETTLE_CYC - 1);
    else if (stb.timeoutLoad) timer <= TMR_W'(TIMEOUT_CYC - 1);
    else if (stb.timerDec)    timer <= timer - TMR_W'(1);
  end

  // power, isolation and burst controls
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrStage1 <= 1'b0;
      pwrStage2 <= 1'b0;
      isoEn     <= 1'b1;
      burstEn   <= 1'b0;
    end else begin
      if (stb.pwr1Set)       pwrStage1 <= 1'b1;
      else if (stb.pwr1Clr)  pwrStage1 <= 1'b0;
      if (stb.pwr2Set)       pwrStage2 <= 1'b1;
      else if (stb.pwr2Clr)  pwrStage2 <= 1'b0;
      if (stb.isoSet)        isoEn     <= 1'b1;
      else if (stb.isoClr)   isoEn     <= 1'b0;
      if (stb.burstSet)      burstEn   <= 1'b1;
      else if (stb.burstClr) burstEn   <= 1'b0;
    end
  end

  // fuse macro request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fuseAddr     <= '0;
      fuseRdStrobe <= 1'b0;
    end else begin
      fuseRdStrobe <= stb.rdIssue;
      if (stb.rdIssue) fuseAddr <= curAddr;
    end
  end

  // output stream and completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      errQ     <= 1'b0;
      done     <= 1'b0;
      busyErr  <= 1'b0;
    end else begin
      outValid <= stb.capture;
      if (stb.capture) outData <= fuseData;
      if (stb.loadCmd)     errQ <= 1'b0;
      else if (stb.errSet) errQ <= 1'b1;
      done    <= stb.doneSet;
      busyErr <= stb.doneSet & errQ;
    end
  end

endmodule

// File: rtl/fuse_read_seq.sv
module fuse_read_seq
  import fuse_read_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int CNT_W       = 8,
  parameter int SETTLE_CYC  = 100000,
  parameter int TIMEOUT_CYC = 100000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              burstCfg,
  output logic [ADDR_W-1:0] fuseAddr,
  output logic              fuseRdStrobe,
  input  logic              fuseReady,
  input  logic [7:0]        fuseData,
  output logic              pwrStage1,
  output logic              pwrStage2,
  output logic              isoEn,
  output logic              burstEn,
  output logic              outValid,
  output logic [7:0]        outData,
  output logic              done,
  output logic              busyErr
);

  seqStrobe_t stb;
  seqStatus_t sts;

  fuse_read_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .fuseReady (fuseReady),
    .sts       (sts),
    .stb       (stb)
  );

  fuse_read_seq_dp #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .SETTLE_CYC  (SETTLE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .startAddr    (startAddr),
    .byteCount    (byteCount),
    .burstCfg     (burstCfg),
    .fuseData     (fuseData),
    .sts          (sts),
    .fuseAddr     (fuseAddr),
    .fuseRdStrobe (fuseRdStrobe),
    .pwrStage1    (pwrStage1),
    .pwrStage2    (pwrStage2),
    .isoEn        (isoEn),
    .burstEn      (burstEn),
    .outValid     (outValid),
    .outData      (outData),
    .done         (done),
    .busyErr      (busyErr)
  );

endmodule

// File: rtl/fuse_read_seq_chk.sv
module fuse_read_seq_chk (
  input logic clk,
  input logic rstN,
  input logic fuseRdStrobe,
  input logic pwrStage1,
  input logic pwrStage2,
  input logic isoEn,
  input logic burstEn,
  input logic outValid,
  input logic done,
  input logic busyErr
);

  p_stage2_needs_stage1_r2: assert property (@(posedge clk) disable iff (!rstN)
    pwrStage2 |-> pwrStage1);

  p_iso_while_stage2_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !pwrStage2 |-> isoEn);

  p_strobe_needs_power_r4: assert property (@(posedge clk) disable iff (!rstN)
    fuseRdStrobe |-> (pwrStage1 && pwrStage2 && !isoEn));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    fuseRdStrobe |=> !fuseRdStrobe);

  p_valid_while_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (pwrStage2 && !isoEn));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |-> done);

  p_done_powered_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!pwrStage1 && isoEn));

  p_burst_inside_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    burstEn |-> !isoEn);

endmodule

bind fuse_read_seq fuse_read_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fuseRdStrobe (fuseRdStrobe),
  .pwrStage1    (pwrStage1),
  .pwrStage2    (pwrStage2),
  .isoEn        (isoEn),
  .burstEn      (burstEn),
  .outValid     (outValid),
  .done         (done),
  .busyErr      (busyErr)
);

// File: tb/tb_fuse_read_seq.sv
module tb_fuse_read_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 11;
  localparam int CNT_W   = 8;
  localparam int SETTLE  = 8;
  localparam int TIMEOUT = 50;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [CNT_W-1:0]  byteCount = '0;
  logic              burstCfg = 1'b0;
  logic [ADDR_W-1:0] fuseAddr;
  logic              fuseRdStrobe;
  logic              fuseReady;
  logic [7:0]        fuseData;
  logic              pwrStage1, pwrStage2, isoEn, burstEn;
  logic              outValid, done, busyErr;
  logic [7:0]        outData;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_read_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TIMEOUT)
  ) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .byteCount(byteCount), .burstCfg(burstCfg), .fuseAddr(fuseAddr),
    .fuseRdStrobe(fuseRdStrobe), .fuseReady(fuseReady), .fuseData(fuseData),
    .pwrStage1(pwrStage1), .pwrStage2(pwrStage2), .isoEn(isoEn), .burstEn(burstEn),
    .outValid(outValid), .outData(outData), .done(done), .busyErr(busyErr)
  );

  function automatic logic [7:0] fmem(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = a * ADDR_W'(37) + ADDR_W'(11);
    return m[7:0] ^ 8'(a >> 3);
  endfunction

  // fuse macro model: ready drops when a strobe is seen, returns after lat cycles
  int lat = 2;
  int dead = -1;
  logic              monClr = 1'b0;
  logic              mRdy, mPend;
  logic [7:0]        mDat;
  logic [ADDR_W-1:0] mA;
  int                mDly, mResp;
  assign fuseReady = mRdy;
  assign fuseData  = mDat;

  always @(posedge clk) begin
    if (!rstN) begin
      mRdy <= 1'b1; mDat <= 8'hEE; mPend <= 1'b0; mDly <= 0; mA <= '0; mResp <= 0;
    end else begin
      if (monClr) mResp <= 0;
      if (fuseRdStrobe) begin
        mRdy <= 1'b0; mPend <= 1'b1; mDly <= lat; mA <= fuseAddr;
      end else if (mPend && !(dead >= 0 && mResp >= dead)) begin
        if (mDly == 0) begin
          mRdy <= 1'b1; mDat <= fmem(mA); mPend <= 1'b0; mResp <= mResp + 1;
        end else mDly <= mDly - 1;
      end
    end
  end

  // port monitor, sampled on the falling edge
  int cyc = 0;
  int tS1r, tS2r, tIsoF, tBr, tBf, tIsoR, tS2f, tS1f, tDone, tFirstStb;
  int nStb, nByte, nDone;
  logic errAtDone, burstSeen;
  logic [ADDR_W-1:0] stbAddr [64];
  logic [7:0]        bytes   [64];
  logic p1, p2, pi, pb;

  always @(negedge clk) begin
    cyc++;
    if (monClr) begin
      tS1r = -1; tS2r = -1; tIsoF = -1; tBr = -1; tBf = -1; tIsoR = -1;
      tS2f = -1; tS1f = -1; tDone = -1; tFirstStb = -1;
      nStb = 0; nByte = 0; nDone = 0; errAtDone = 1'b0; burstSeen = 1'b0;
    end else begin
      if (pwrStage1 && !p1) tS1r = cyc;
      if (!pwrStage1 && p1) tS1f = cyc;
      if (pwrStage2 && !p2) tS2r = cyc;
      if (!pwrStage2 && p2) tS2f = cyc;
      if (!isoEn && pi)     tIsoF = cyc;
      if (isoEn && !pi)     tIsoR = cyc;
      if (burstEn && !pb)   tBr = cyc;
      if (!burstEn && pb)   tBf = cyc;
      if (burstEn)          burstSeen = 1'b1;
      if (fuseRdStrobe) begin
        if (tFirstStb < 0) tFirstStb = cyc;
        if (nStb < 64) stbAddr[nStb] = fuseAddr;
        nStb++;
      end
      if (outValid) begin
        if (nByte < 64) bytes[nByte] = outData;
        nByte++;
      end
      if (done) begin
        nDone++; tDone = cyc; errAtDone = busyErr;
      end
    end
    p1 = pwrStage1; p2 = pwrStage2; pi = isoEn; pb = burstEn;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(negedge clk); monClr = 1'b1;
    @(negedge clk); monClr = 1'b0;
  endtask

  task automatic issue(input logic [ADDR_W-1:0] a, input int n, input logic b);
    @(negedge clk);
    startAddr = a; byteCount = CNT_W'(n); burstCfg = b; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 4000 && nDone == 0; i++) @(negedge clk);
    check(nDone == 1, "R7 done reached", nDone, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    check(isoEn == 1'b1, "R1 isoEn", int'(isoEn), 1);
    check(!pwrStage1 && !pwrStage2, "R1 power off", int'({pwrStage1, pwrStage2}), 0);
    check(!burstEn && !fuseRdStrobe, "R1 burst/strobe", int'({burstEn, fuseRdStrobe}), 0);
    check(!outValid && !done && !busyErr, "R1 outputs", int'({outValid, done, busyErr}), 0);
  endtask

  // generic read scenario with full sequence checks
  task automatic run_read(input logic [ADDR_W-1:0] a, input int n, input logic b,
                          input int l, input int d, input int expBytes, input logic expErr);
    int expStb;
    lat = l; dead = d;
    clearMon();
    issue(a, n, b);
    waitDone();
    expStb = expErr ? expBytes + 1 : n;
    check(nByte == expBytes, "R5 byte count", nByte, expBytes);
    check(nStb == expStb, "R7 strobe count", nStb, expStb);
    for (int i = 0; i < expBytes && i < 64; i++) begin
      check(bytes[i] == fmem(ADDR_W'(a + ADDR_W'(i))), "R4 byte value", int'(bytes[i]),
            int'(fmem(ADDR_W'(a + ADDR_W'(i)))));
    end
    for (int i = 0; i < expStb && i < 64; i++) begin
      check(stbAddr[i] == ADDR_W'(a + ADDR_W'(i)), "R5 address order", int'(stbAddr[i]),
            int'(ADDR_W'(a + ADDR_W'(i))));
    end
    check(errAtDone == expErr, "R7 busyErr at done", int'(errAtDone), int'(expErr));
    check(tS2r - tS1r == SETTLE, "R2 settle gap up", tS2r - tS1r, SETTLE);
    check(tIsoF - tS2r == 1, "R2 iso release", tIsoF - tS2r, 1);
    check(tFirstStb > tIsoF, "R2 strobe after release", tFirstStb, tIsoF + 1);
    check(tS2f - tIsoR == 1, "R3 stage2 off after iso", tS2f - tIsoR, 1);
    check(tS1f - tS2f == SETTLE, "R3 settle gap down", tS1f - tS2f, SETTLE);
    check(tDone - tS1f == 1, "R3 done after stage1 off", tDone - tS1f, 1);
    check(!pwrStage1 && !pwrStage2 && isoEn, "R3 final power state",
          int'({pwrStage1, pwrStage2, isoEn}), 1);
    if (b) begin
      check(tBr - tIsoF == 1, "R8 burst on", tBr - tIsoF, 1);
      check(tIsoR - tBf == 1, "R8 burst off", tIsoR - tBf, 1);
    end else begin
      check(!burstSeen, "R8 burst stays low", int'(burstSeen), 0);
    end
  endtask

  task automatic test_basic();        run_read(11'h010, 5, 1'b0, 2, -1, 5, 1'b0); endtask
  task automatic test_burst();        run_read(11'h7F0, 4, 1'b1, 0, -1, 4, 1'b0); endtask
  task automatic test_late_ok();      run_read(11'h155, 2, 1'b0, TIMEOUT - 2, -1, 2, 1'b0); endtask
  task automatic test_late_timeout(); run_read(11'h200, 3, 1'b0, TIMEOUT - 1, -1, 0, 1'b1); endtask
  task automatic test_mid_abort();    run_read(11'h0A0, 6, 1'b1, 1, 2, 2, 1'b1); endtask
  task automatic test_after_err();    run_read(11'h003, 1, 1'b0, 3, -1, 1, 1'b0); endtask

  task automatic test_zero();
    lat = 1; dead = -1;
    clearMon();
    issue(11'h040, 0, 1'b1);
    for (int i = 0; i < 10 && nDone == 0; i++) @(negedge clk);
    check(nDone == 1, "R6 zero-count done", nDone, 1);
    check(!errAtDone, "R6 zero-count no error", int'(errAtDone), 0);
    repeat (4) @(negedge clk);
    check(nStb == 0, "R6 no strobe", nStb, 0);
    check(tS1r == -1 && !burstSeen && isoEn, "R6 no power change", tS1r, -1);
  endtask

  task automatic test_busy_ignore();
    lat = 1; dead = -1;
    clearMon();
    issue(11'h020, 3, 1'b0);
    repeat (4) @(negedge clk);
    issue(11'h300, 9, 1'b1);
    waitDone();
    repeat (40) @(negedge clk);
    check(nDone == 1, "R9 single done", nDone, 1);
    check(nStb == 3, "R9 strobe count", nStb, 3);
    check(stbAddr[0] == 11'h020 && stbAddr[2] == 11'h022, "R9 addresses kept",
          int'(stbAddr[2]), 'h22);
    check(!burstSeen, "R9 burst config kept", int'(burstSeen), 0);
  endtask

  initial begin
    monClr = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    monClr = 1'b0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_burst();
    test_zero();
    test_late_ok();
    test_late_timeout();
    test_mid_abort();
    test_after_err();
    test_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule